// File: doc/BRIEF.md
# Burst Dimming Timing Generator

This block creates the lamp-enable waveform that a backlight inverter uses for burst-mode dimming. The lamp is run at a fixed current amplitude. Brightness is set by the fraction of each burst period during which the lamp is allowed to run. The burst period is counted from a source clock, and a decoded three-state mode input chooses that source. The source is either an internal clock at half the rate of the lamp drive output A, or an external dimming clock. In analog mode there is no bursting at all: the lamp stays enabled, and the polarity-corrected brightness word is passed on to set the current amplitude.

A second decoded three-state input divides the chosen source by 2, 4 or 8 before it steps an 8-bit burst counter. The lamp is enabled while the counter is below the brightness word. That word is inverted first when reverse polarity is selected. A new mode or divider choice made while bursting is held back until the counter wraps, so no burst is ever cut short. All three-state inputs arrive already decoded as 2-bit codes, and every input is sampled on the system clock.

Top module: `burst_dim_gen`

## Requirements
- R1: The mode code selects the behaviour: 2'b00 gives digital dimming from the internal source, 2'b10 gives digital dimming from the external dim clock, and 2'b01 or 2'b11 gives analog mode.
- R2: In analog mode, `lamp_en` is held high and the burst counter stays at zero, whatever the brightness word.
- R3: The internal source gives one tick for every second cycle in which `drv_a_tick` is high.
- R4: Each rising edge of `ext_dim_clk` gives one source tick, after a two-stage synchronizer.
- R5: The divider code sets the number of source ticks per counter step: 2'b10 gives 2, 2'b01 or 2'b11 gives 4, and 2'b00 gives 8.
- R6: The burst counter is 8 bits wide, so one period is 256 steps. `lamp_en` is high during the steps in which the counter is below the effective brightness. A word of 0 keeps the lamp dark, and a word of 255 keeps it lit for 255 of the 256 steps.
- R7: Polarity code 2'b00 selects reverse polarity, where the effective brightness is the bitwise inverse of `bright`. Any other code passes `bright` unchanged. `level_out` always shows the effective brightness.
- R8: While in a digital mode, changes to the mode or divider code take effect only when the counter wraps from 255 to 0. While in analog mode, a new code takes effect on the next clock.
- R9: Reset is synchronous and active high. It puts the block in analog mode with the counter at zero, so `lamp_en` is high while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Decoded three-state dimming mode code |
| div_sel | input | 2 | Decoded three-state burst divider code |
| pol_sel | input | 2 | Decoded three-state polarity code |
| drv_a_tick | input | 1 | One-cycle strobe per lamp drive A cycle |
| ext_dim_clk | input | 1 | Raw external dimming clock |
| bright | input | 8 | Digital brightness word |
| lamp_en | output | 1 | Burst lamp-enable |
| level_out | output | 8 | Polarity-corrected brightness |

## Verification
Most internal faults show up as a wrong count of lit cycles over one burst period. A bad divider, source select, synchronizer or compare point shifts that count by a whole number of steps, so it is caught within one period of at most a few thousand cycles. A config register that loads too early shows up in the first burst after a code change: the lit phase then has the new length instead of the old one. An analog mode that fails to hold the counter shows up within a few cycles as `lamp_en` dropping while the brightness word is zero.

// File: rtl/burst_dim_pkg.sv
package burst_dim_pkg;

    localparam int PRE_W = 3;

    typedef enum logic [1:0] {
        SRC_ANALOG   = 2'd0,
        SRC_INTERNAL = 2'd1,
        SRC_EXTERNAL = 2'd2
    } dim_mode_e;

    typedef enum logic [1:0] {
        DIV_BY2 = 2'd0,
        DIV_BY4 = 2'd1,
        DIV_BY8 = 2'd2
    } div_e;

    typedef struct packed {
        dim_mode_e mode;
        div_e      div;
    } burst_cfg_t;

    // three-state code: 00 low, 01 mid, 10 high, 11 treated as mid
    function automatic dim_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b00:   return SRC_INTERNAL;
            2'b10:   return SRC_EXTERNAL;
            default: return SRC_ANALOG;
        endcase
    endfunction

    function automatic div_e decode_div(input logic [1:0] code);
        case (code)
            2'b10:   return DIV_BY2;
            2'b00:   return DIV_BY8;
            default: return DIV_BY4;
        endcase
    endfunction

    function automatic logic [PRE_W-1:0] div_last(input div_e d);
        case (d)
            DIV_BY2: return PRE_W'(1);
            DIV_BY8: return PRE_W'(7);
            default: return PRE_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/burst_src_sel.sv
module burst_src_sel
    import burst_dim_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  dim_mode_e mode,
    input  logic      drv_a_tick,
    input  logic      ext_dim_clk,
    output logic      src_tick
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         ext_prev_q;
    logic         half_q;
    logic         ext_rise;
    logic         int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            ext_prev_q <= 1'b0;
            half_q     <= 1'b0;
        end else begin
            sync_q     <= {sync_q[TOP-1:0], ext_dim_clk};
            ext_prev_q <= sync_q[TOP];
            if (drv_a_tick) half_q <= ~half_q;
        end
    end

    assign ext_rise = sync_q[TOP] & ~ext_prev_q;
    assign int_tick = drv_a_tick & half_q;

    always_comb begin
        case (mode)
            SRC_INTERNAL: src_tick = int_tick;
            SRC_EXTERNAL: src_tick = ext_rise;
            default:      src_tick = 1'b0;
        endcase
    end

    // R3: internal ticks never come back to back
    p_int_alternate_r3: assert property (@(posedge clk) disable iff (rst)
        int_tick |=> !int_tick);

    // R4: one tick per external edge
    p_ext_single_r4: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);

endmodule

// File: rtl/burst_prescale.sv
module burst_prescale
    import burst_dim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic src_tick,
    input  div_e div,
    output logic step
);
    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] last;

    assign last = div_last(div);
    assign step = src_tick && (pc_q == last);

    always_ff @(posedge clk) begin
        if (rst || clear)  pc_q <= '0;
        else if (src_tick) pc_q <= step ? '0 : pc_q + 1'b1;
    end

    // R5: prescale count stays inside the selected ratio
    p_pc_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        pc_q <= div_last(div));

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_dim_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  burst_cfg_t       cfg_req,
    output burst_cfg_t       cfg_q,
    output logic [CNT_W-1:0] count_q,
    output logic             restart
);
    logic wrap;

    assign wrap    = step && (count_q == '1);
    assign restart = (cfg_q.mode == SRC_ANALOG) || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= SRC_ANALOG;
            cfg_q.div  <= DIV_BY4;
            count_q    <= '0;
        end else if (restart) begin
            cfg_q   <= cfg_req;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    // R8: active settings only move at a period boundary or from analog
    p_cfg_held_r8: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(cfg_q));

    // R2: analog mode keeps the counter parked
    p_analog_park_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SRC_ANALOG) |=> (count_q == '0));

    // R6: each step advances the counter by one
    p_step_adv_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !restart) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/burst_dim_gen.sv
module burst_dim_gen
    import burst_dim_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       div_sel,
    input  logic [1:0]       pol_sel,
    input  logic             drv_a_tick,
    input  logic             ext_dim_clk,
    input  logic [CNT_W-1:0] bright,
    output logic             lamp_en,
    output logic [CNT_W-1:0] level_out
);
    burst_cfg_t       cfg_req;
    burst_cfg_t       cfg_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] eff;
    logic             src_tick;
    logic             step;
    logic             restart;

    assign cfg_req.mode = decode_mode(mode_sel);
    assign cfg_req.div  = decode_div(div_sel);

    // R7: low code on the polarity input reverses the brightness sense
    assign eff       = (pol_sel == 2'b00) ? ~bright : bright;
    assign level_out = eff;

    burst_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk         (clk),
        .rst         (rst),
        .mode        (cfg_q.mode),
        .drv_a_tick  (drv_a_tick),
        .ext_dim_clk (ext_dim_clk),
        .src_tick    (src_tick)
    );

    burst_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .src_tick (src_tick),
        .div      (cfg_q.div),
        .step     (step)
    );

    burst_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .cfg_req (cfg_req),
        .cfg_q   (cfg_q),
        .count_q (count_q),
        .restart (restart)
    );

    always_comb begin
        if (cfg_q.mode == SRC_ANALOG) lamp_en = 1'b1;
        else                          lamp_en = (count_q < eff);
    end

    // R6: a zero effective level never lights the lamp while bursting
    p_dark_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.mode != SRC_ANALOG) && (level_out == '0)) |-> !lamp_en);

endmodule

// File: tb/burst_dim_gen_test.sv
module burst_dim_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b01;
    logic [1:0] div_sel = 2'b01;
    logic [1:0] pol_sel = 2'b01;
    logic       drv_a_tick = 1'b0;
    logic       ext_dim_clk = 1'b0;
    logic [7:0] bright = 8'd0;
    logic       lamp_en;
    logic [7:0] level_out;

    int checks = 0;
    int errors = 0;
    int gap = 1;
    int tick_cnt = 0;
    int ext_cnt = 0;

    always #5 clk = ~clk;

    burst_dim_gen uut (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .div_sel     (div_sel),
        .pol_sel     (pol_sel),
        .drv_a_tick  (drv_a_tick),
        .ext_dim_clk (ext_dim_clk),
        .bright      (bright),
        .lamp_en     (lamp_en),
        .level_out   (level_out)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  div;
        logic [1:0]  pol;
        logic [3:0]  gap;
        logic [7:0]  bright;
        logic [15:0] period;
        logic [15:0] high;
        logic [7:0]  level;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b10, 2'b01, 4'd1, 8'd64,  16'd1024, 16'd256,  8'd64},
        '{2'b00, 2'b01, 2'b01, 4'd1, 8'd200, 16'd2048, 16'd1600, 8'd200},
        '{2'b00, 2'b00, 2'b01, 4'd1, 8'd10,  16'd4096, 16'd160,  8'd10},
        '{2'b00, 2'b11, 2'b00, 4'd1, 8'd48,  16'd2048, 16'd1656, 8'd207},
        '{2'b10, 2'b10, 2'b01, 4'd1, 8'd128, 16'd3072, 16'd1536, 8'd128},
        '{2'b10, 2'b01, 2'b00, 4'd1, 8'd255, 16'd6144, 16'd0,    8'd0},
        '{2'b00, 2'b10, 2'b01, 4'd1, 8'd0,   16'd1024, 16'd0,    8'd0},
        '{2'b00, 2'b10, 2'b01, 4'd1, 8'd255, 16'd1024, 16'd1020, 8'd255},
        '{2'b01, 2'b10, 2'b00, 4'd1, 8'd5,   16'd1024, 16'd1024, 8'd250},
        '{2'b11, 2'b00, 2'b01, 4'd1, 8'd0,   16'd1024, 16'd1024, 8'd0},
        '{2'b00, 2'b10, 2'b01, 4'd3, 8'd100, 16'd3072, 16'd1200, 8'd100}
    };

    // drive strobe every gap cycles, external clock 3 high / 3 low
    initial begin
        forever begin
            @(negedge clk);
            tick_cnt = (tick_cnt + 1 >= gap) ? 0 : tick_cnt + 1;
            drv_a_tick = (tick_cnt == 0);
            ext_cnt = (ext_cnt == 5) ? 0 : ext_cnt + 1;
            ext_dim_clk = (ext_cnt < 3);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edge(input logic level, output int cycles);
        logic prev;
        cycles = 0;
        prev = lamp_en;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            cycles++;
            if (lamp_en == level && prev != level) break;
            prev = lamp_en;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        int n;

        // R9: reset state is analog, lamp lit even with zero brightness
        mode_sel = 2'b00;
        bright = 8'd0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 lamp_en in reset", int'(lamp_en), 1);

        // vector table: R1 R3 R4 R5 R6 R7 R2
        for (int v = 0; v < NVEC; v++) begin
            mode_sel = VECS[v].mode;
            div_sel  = VECS[v].div;
            pol_sel  = VECS[v].pol;
            bright   = VECS[v].bright;
            gap      = int'(VECS[v].gap);
            do_reset();
            repeat (40) @(negedge clk);
            chk($sformatf("R7 level vec %0d", v), int'(level_out), int'(VECS[v].level));
            hi = 0;
            for (int c = 0; c < int'(VECS[v].period); c++) begin
                @(negedge clk);
                hi += int'(lamp_en);
            end
            chk($sformatf("R6 R5 R1 lit cycles vec %0d", v), hi, int'(VECS[v].high));
        end

        // R8: divider change mid-burst waits for wrap
        gap = 1;
        mode_sel = 2'b00;
        div_sel = 2'b10;
        pol_sel = 2'b01;
        bright = 8'd128;
        do_reset();
        wait_edge(1'b0, n);
        wait_edge(1'b1, n);
        repeat (100) @(negedge clk);
        div_sel = 2'b00;
        wait_edge(1'b0, n);
        chk("R8 old divider lit phase", n + 100, 512);
        wait_edge(1'b1, n);
        chk("R8 old divider dark phase", n, 512);
        wait_edge(1'b0, n);
        chk("R8 new divider lit phase", n, 2048);

        // R8: switch to analog while dark is deferred to the wrap
        mode_sel = 2'b01;
        repeat (5) @(negedge clk);
        chk("R8 analog request deferred", int'(lamp_en), 0);
        wait_edge(1'b1, n);
        chk("R8 dark phase before analog", n + 5, 2048);

        // R2: analog ignores brightness for the burst
        bright = 8'd0;
        repeat (300) @(negedge clk);
        chk("R2 analog lamp lit", int'(lamp_en), 1);
        chk("R7 analog level", int'(level_out), 0);

        // R8: leaving analog acts on the next clock
        mode_sel = 2'b00;
        repeat (3) @(negedge clk);
        chk("R8 digital from analog immediate", int'(lamp_en), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule